// File: doc/BRIEF.md
# Sequential Single-Precision Multiplier with Radix-4 Recoding

This block multiplies two 32-bit binary floating-point operands in the single-precision interchange format and returns the 32-bit product together with three exception flags: overflow, underflow and invalid. The product sign is the exclusive OR of the operand signs. The biased product exponent is the sum of the two stored exponents less one bias of 127. The 48-bit product of the two 24-bit significands (hidden one restored) is built by a radix-4 recoded multiplier. That multiplier looks at overlapping three-bit windows of the multiplier operand, so every partial product is 0, ±1 or ±2 times the multiplicand and no precomputed multiple is needed.

The datapath is iterative. One recoded partial product is added to a two's-complement accumulator per clock, so 13 partial products cover the zero-padded 24-bit multiplier. A final cycle then normalizes, truncates and checks for exceptions. A one-cycle `start` pulse with both operands present starts an operation. `done` pulses for exactly one cycle when the registered result and flags are valid. Operands with a zero exponent field are flushed to zero, and rounding is truncation only.

Top module: `fpmul_booth`

## Requirements
- R1: For a finite nonzero product, result bit 31 equals op_a bit 31 XOR op_b bit 31.
- R2: For finite nonzero operands, let P be the 48-bit product of {1,frac_a} and {1,frac_b}, and let E = exp_a + exp_b - 127. If P bit 47 is set, the fraction field is P[46:24] and E is incremented by one. Otherwise the fraction field is P[45:23]. The exponent field (bits 30:23) receives E.
- R3: If the final E is 255 or more, the result is signed infinity (exponent field all ones, fraction zero) and ovf is 1.
- R4: If the final E is 0 or less, the result is signed zero (bits 30:0 zero) and unf is 1.
- R5: If either operand is a NaN (exponent 255, fraction nonzero), the result is 0x7FC00000 and all three flags are 0.
- R6: Zero times infinity, in either order, gives 0x7FC00000 with inv set to 1.
- R7: Infinity times a finite nonzero value gives infinity with the XOR sign, and no flag is set.
- R8: An operand whose exponent field is 0 (zero or subnormal) times a finite value gives zero with the XOR sign, and no flag is set.
- R9: done rises exactly 14 clock edges after the edge that accepts start and stays high for one cycle. result and the flags keep their values until the next done.
- R10: A start pulse while an operation is in flight is ignored. The current result and its timing are not changed, and no extra done follows.
- R11: At most one of ovf, unf and inv is set at a time. After synchronous reset, done, result and all flags are 0.
- R12: The fraction is truncated. Product bits below the selected field never change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op_a | input | 32 | Multiplicand, single precision |
| op_b | input | 32 | Multiplier, single precision |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 32 | Product, single precision |
| ovf | output | 1 | Overflow flag |
| unf | output | 1 | Underflow flag |
| inv | output | 1 | Invalid-operation flag |

## Verification
The hardest cases to reach from the ports are the ones where normalization moves an exponent across a limit. One case is a product at or above 2 that pushes an exponent sum of 254 into overflow. The other lifts a sum of 0 out of underflow. Random operands almost never land there, so the stimulus builds operand pairs whose exponent fields add to exactly 381 or 127, with significands of 1.0 or 1.5 chosen so that product bit 47 is clear or set. A second scenario pulses start with different operands in the middle of a run and checks that the first result arrives unchanged and on time.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } fpm_state_e;

  typedef enum logic [1:0] {
    CLS_FIN,
    CLS_ZERO,
    CLS_INF,
    CLS_NAN
  } fpm_cls_e;
endpackage

// File: rtl/fpm_booth_pp.sv
module fpm_booth_pp #(
  parameter int SIG_W = 24
) (
  input  logic [2:0]       grp,
  input  logic [SIG_W-1:0] mcand,
  output logic [SIG_W+1:0] pp
);
  logic [SIG_W+1:0] m1;
  logic [SIG_W+1:0] m2;

  assign m1 = {2'b00, mcand};
  assign m2 = {1'b0, mcand, 1'b0};

  // digit in {-2,-1,0,+1,+2}; negatives in two's complement
  always_comb begin
    case (grp)
      3'b001, 3'b010: pp = m1;
      3'b011:         pp = m2;
      3'b100:         pp = -m2;
      3'b101, 3'b110: pp = -m1;
      default:        pp = '0;
    endcase
  end
endmodule

// File: rtl/fpm_pack.sv
module fpm_pack
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int EW2    = EXP_W + 2,
  localparam int TOP_W  = FRAC_W + 2
) (
  input  logic                  sign,
  input  logic signed [EW2-1:0] exp_sum,
  input  logic [TOP_W-1:0]      prod_top,
  input  fpm_cls_e              cls_a,
  input  fpm_cls_e              cls_b,
  output logic [WORD_W-1:0]     res,
  output logic                  ovf,
  output logic                  unf,
  output logic                  inv
);
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [EW2-1:0] EMAX = EW2'((1 << EXP_W) - 1);

  logic signed [EW2-1:0] e_fin;
  logic [FRAC_W-1:0]     frac;
  logic                  any_nan, zero_inf, any_inf, any_zero;

  assign any_nan  = (cls_a == CLS_NAN) || (cls_b == CLS_NAN);
  assign zero_inf = ((cls_a == CLS_ZERO) && (cls_b == CLS_INF)) ||
                    ((cls_a == CLS_INF) && (cls_b == CLS_ZERO));
  assign any_inf  = (cls_a == CLS_INF) || (cls_b == CLS_INF);
  assign any_zero = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);

  always_comb begin
    if (prod_top[TOP_W-1]) begin
      e_fin = exp_sum + EW2'(1);
      frac  = prod_top[TOP_W-2:1];
    end else begin
      e_fin = exp_sum;
      frac  = prod_top[TOP_W-3:0];
    end
  end

  always_comb begin
    ovf = 1'b0;
    unf = 1'b0;
    inv = 1'b0;
    if (any_nan || zero_inf) begin
      res = QNAN;
      inv = zero_inf;
    end else if (any_inf) begin
      res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (any_zero) begin
      res = {sign, {(WORD_W-1){1'b0}}};
    end else if (e_fin >= EMAX) begin
      res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf = 1'b1;
    end else if (e_fin <= 0) begin
      res = {sign, {(WORD_W-1){1'b0}}};
      unf = 1'b1;
    end else begin
      res = {sign, e_fin[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fpmul_booth.sv
module fpmul_booth
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              done,
  output logic [WORD_W-1:0] result,
  output logic              ovf,
  output logic              unf,
  output logic              inv
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam int NPP    = SIG_W / 2 + 1;
  localparam int MREG_W = 2 * NPP + 1;
  localparam int CNT_W  = $clog2(NPP);
  localparam int EW2    = EXP_W + 2;
  localparam int TOP_W  = FRAC_W + 2;
  localparam logic signed [EW2-1:0] BIAS_S = EW2'((1 << (EXP_W - 1)) - 1);

  function automatic fpm_cls_e classify(input logic [WORD_W-1:0] v);
    logic [EXP_W-1:0] e;
    e = v[WORD_W-2 -: EXP_W];
    if (e == '0)                     return CLS_ZERO;
    if (e != {EXP_W{1'b1}})          return CLS_FIN;
    if (v[FRAC_W-1:0] == '0)         return CLS_INF;
    return CLS_NAN;
  endfunction

  logic [1:0][WORD_W-1:0] ops;
  fpm_cls_e               cls_in [2];

  assign ops = {op_b, op_a};

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    assign cls_in[gi] = classify(ops[gi]);
  end

  fpm_state_e            state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [SIG_W-1:0]      mcand_q;
  logic [MREG_W-1:0]     mplr_q;
  logic [ACC_W-1:0]      acc_q;
  logic                  sign_q;
  logic signed [EW2-1:0] exp_q;
  fpm_cls_e              cls_a_q, cls_b_q;

  logic [SIG_W+1:0]      pp;
  logic [ACC_W-1:0]      pp_ext, pp_sh;
  logic [WORD_W-1:0]     pk_res;
  logic                  pk_ovf, pk_unf, pk_inv;

  fpm_booth_pp #(.SIG_W(SIG_W)) u_pp (
    .grp   (mplr_q[2:0]),
    .mcand (mcand_q),
    .pp    (pp)
  );

  assign pp_ext = {{(ACC_W-SIG_W-2){pp[SIG_W+1]}}, pp};
  assign pp_sh  = pp_ext << {cnt_q, 1'b0};

  fpm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .sign     (sign_q),
    .exp_sum  (exp_q),
    .prod_top (acc_q[PROD_W-1 -: TOP_W]),
    .cls_a    (cls_a_q),
    .cls_b    (cls_b_q),
    .res      (pk_res),
    .ovf      (pk_ovf),
    .unf      (pk_unf),
    .inv      (pk_inv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
      acc_q   <= '0;
      sign_q  <= 1'b0;
      exp_q   <= '0;
      cls_a_q <= CLS_ZERO;
      cls_b_q <= CLS_ZERO;
      done    <= 1'b0;
      result  <= '0;
      ovf     <= 1'b0;
      unf     <= 1'b0;
      inv     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mcand_q <= {1'b1, op_a[FRAC_W-1:0]};
            mplr_q  <= {{(MREG_W-SIG_W-1){1'b0}}, 1'b1, op_b[FRAC_W-1:0], 1'b0};
            acc_q   <= '0;
            cnt_q   <= '0;
            sign_q  <= op_a[WORD_W-1] ^ op_b[WORD_W-1];
            exp_q   <= $signed({2'b00, op_a[WORD_W-2 -: EXP_W]}) +
                       $signed({2'b00, op_b[WORD_W-2 -: EXP_W]}) - BIAS_S;
            cls_a_q <= cls_in[0];
            cls_b_q <= cls_in[1];
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc_q  <= acc_q + pp_sh;
          mplr_q <= mplr_q >> 2;
          cnt_q  <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(NPP - 1)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          result  <= pk_res;
          ovf     <= pk_ovf;
          unf     <= pk_unf;
          inv     <= pk_inv;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpmul_booth_chk.sv
module fpmul_booth_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int LAT    = (FRAC_W + 1) / 2 + 2,
  localparam int LC_W   = $clog2(LAT + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic [WORD_W-1:0] result,
  input logic              ovf,
  input logic              unf,
  input logic              inv
);
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic            busy_c;
  logic [LC_W-1:0] cnt_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_c <= 1'b0;
      cnt_c  <= '0;
    end else if (start && (!busy_c || done)) begin
      busy_c <= 1'b1;
      cnt_c  <= '0;
    end else if (busy_c && done) begin
      busy_c <= 1'b0;
    end else if (busy_c && cnt_c != LC_W'(LAT)) begin
      cnt_c <= cnt_c + LC_W'(1);
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_c && cnt_c == LC_W'(LAT)));
  a_r10_done_on_time: assert property (@(posedge clk) disable iff (rst)
    (busy_c && cnt_c == LC_W'(LAT)) |-> done);
  a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable({ovf, unf, inv})));
  a_r6_invalid_qnan: assert property (@(posedge clk) disable iff (rst)
    inv |-> (result == QNAN));
  a_r3_ovf_inf: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  a_r4_unf_zero: assert property (@(posedge clk) disable iff (rst)
    unf |-> (result[WORD_W-2:0] == '0));
  a_r11_flags_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf, unf, inv}));
endmodule

bind fpmul_booth fpmul_booth_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .done   (done),
  .result (result),
  .ovf    (ovf),
  .unf    (unf),
  .inv    (inv)
);

// File: tb/fpmul_booth_tb_top.sv
module fpmul_booth_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 14;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        done;
  logic [31:0] result;
  logic        ovf, unf, inv;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpmul_booth dut_i (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .done(done), .result(result), .ovf(ovf), .unf(unf), .inv(inv)
  );

  // behavioural reference: {inv, unf, ovf, result}
  function automatic logic [34:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    int ea = int'(a[30:23]);
    int eb = int'(b[30:23]);
    bit s  = a[31] ^ b[31];
    bit na = (ea == 255) && (a[22:0] != 0);
    bit nb = (eb == 255) && (b[22:0] != 0);
    bit ia = (ea == 255) && (a[22:0] == 0);
    bit ib = (eb == 255) && (b[22:0] == 0);
    bit za = (ea == 0);
    bit zb = (eb == 0);
    longint unsigned p;
    int e;
    logic [22:0] fr;
    if (na || nb) return {3'b000, 32'h7FC00000};
    if ((za && ib) || (ia && zb)) return {3'b100, 32'h7FC00000};
    if (ia || ib) return {3'b000, s, 8'hFF, 23'd0};
    if (za || zb) return {3'b000, s, 31'd0};
    p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
    e = ea + eb - 127;
    if (p[47]) begin
      e++;
      fr = p[46:24];
    end else begin
      fr = p[45:23];
    end
    if (e >= 255) return {3'b001, s, 8'hFF, 23'd0};
    if (e <= 0)   return {3'b010, s, 31'd0};
    return {3'b000, s, e[7:0], fr};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one operation; if poke, a second start arrives mid-run and must be ignored (R10)
  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input string req, input bit poke);
    logic [34:0] exp_v = ref_mul(a, b);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk);
      check(done == 1'b0, poke ? "R10" : "R9", "done early", 64'(done), 64'd0);
      if (poke && k == 5) begin
        op_a = 32'h40400000; op_b = 32'hC0A00000; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    @(negedge clk);
    check(done == 1'b1, "R9", "done at latency", 64'(done), 64'd1);
    check({inv, unf, ovf, result} == exp_v, req, "result/flags",
          64'({inv, unf, ovf, result}), 64'(exp_v));
    @(negedge clk);
    check(done == 1'b0, "R9", "done one cycle", 64'(done), 64'd0);
    check({inv, unf, ovf, result} == exp_v, "R9", "result held",
          64'({inv, unf, ovf, result}), 64'(exp_v));
    if (poke) begin
      for (int k = 0; k < LAT + 2; k++) begin
        @(negedge clk);
        check(done == 1'b0, "R10", "no extra done", 64'(done), 64'd0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check({done, inv, unf, ovf, result} == '0, "R11", "reset state",
          64'({done, inv, unf, ovf, result}), 64'd0);
    rst = 1'b0;

    run_op(32'h3FC00000, 32'h40000000, "R2", 1'b0);  // 1.5*2 = 3
    run_op(32'h3FC00000, 32'h3FC00000, "R2", 1'b0);  // bit 47 set
    run_op(32'hC0400000, 32'h40A00000, "R1", 1'b0);  // -3*5
    run_op(32'hBF800000, 32'hBF800000, "R1", 1'b0);  // -1*-1
    run_op(32'h3FFFFFFF, 32'h3FFFFFFF, "R12", 1'b0); // truncation
    run_op(32'h3F800001, 32'h3F800001, "R12", 1'b0);
    run_op(32'h7F000000, 32'h40000000, "R3", 1'b0);  // E = 255
    run_op(32'h7F000000, 32'h3F800000, "R2", 1'b0);  // E = 254, no overflow
    run_op(32'hFF400000, 32'h3FC00000, "R3", 1'b0);  // carry pushes to 255
    run_op(32'h7F7FFFFF, 32'h7F7FFFFF, "R3", 1'b0);
    run_op(32'h20000000, 32'h1F800000, "R4", 1'b0);  // E = 0
    run_op(32'h20000000, 32'h20000000, "R2", 1'b0);  // E = 1, smallest normal
    run_op(32'hA0400000, 32'h1FC00000, "R4", 1'b0);  // carry lifts 0 to 1
    run_op(32'h00800000, 32'h00800000, "R4", 1'b0);
    run_op(32'h7FC00001, 32'h3F800000, "R5", 1'b0);
    run_op(32'h3F800000, 32'hFFA00000, "R5", 1'b0);
    run_op(32'h7FC00000, 32'h7F800000, "R5", 1'b0);
    run_op(32'h00000000, 32'h7F800000, "R6", 1'b0);
    run_op(32'hFF800000, 32'h80000000, "R6", 1'b0);
    run_op(32'h7F800000, 32'hC0000000, "R7", 1'b0);
    run_op(32'h7F800000, 32'hFF800000, "R7", 1'b0);
    run_op(32'h00000001, 32'h3F800000, "R8", 1'b0);  // subnormal flushed
    run_op(32'h80000000, 32'h42000000, "R8", 1'b0);
    run_op(32'h40490FDB, 32'h402DF854, "R10", 1'b1);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra = $urandom;
      logic [31:0] rb = $urandom;
      if (i % 3 != 0) begin
        ra[30:23] = 8'(90 + ($urandom % 76));
        rb[30:23] = 8'(90 + ($urandom % 76));
      end
      run_op(ra, rb, "R2", 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule